// File: doc/BRIEF.md
# Basic-Block Successor Checker

This block watches the instruction stream that a processor retires and checks that, inside one function, execution only moves between basic blocks along edges that were worked out before the program ran. A table with one row per block holds three things for each block: its start offset from the function base, and the two blocks that may follow it. Software fills the table through a write port before the application starts. At run time, each retired PC is turned into an offset from the base of the active function. An offset that equals a stored start offset marks entry into that block. The block just entered must be one of the two successors listed for the block that was just left.

Any move into a block counts as a transfer. This covers a taken branch, a jump and plain sequential fall-through into the next block. The instruction retired right after a branch or jump is a transfer target, and it must land exactly on a block start. On the first violation the block raises a sticky invalid flag and freezes the index of the block that was being left. It also applies back-pressure on the retire stream while a transfer target is still being checked. How strict that back-pressure is depends on the mode: a prevention mode holds every retire, and a detection mode holds only further branches and jumps.

Top module: `bb_flow_checker`

## Requirements
- R1: A write with `tbl_we` high stores `tbl_off`, `tbl_s0` and `tbl_s1` as the row whose block index is `tbl_row`. A later write to the same row replaces the old contents. Reset empties every row.
- R2: An accepted retire whose offset `ret_pc - func_base` fits in OFF_W bits and equals the stored offset of a loaded row is an entry into that block. If several rows match, the lowest index wins.
- R3: An entry into block k, made while a current block c exists, is legal only when k equals the s0 or the s1 of row c. Otherwise `invalid` goes high after the second rising edge, counting the edge that accepted the retire.
- R4: Sequential fall-through is treated like a branch. A retire that lands on a block start without a preceding branch or jump is still checked against the successors of the current block.
- R5: A retire that directly follows an accepted retire with `ret_ctrl` = 1 must land on a block start. If its offset matches no row, or lies outside the OFF_W range, `invalid` is raised.
- R6: The first block entry after reset has no predecessor and is accepted without a check.
- R7: `invalid` stays high until reset. `fault_row` holds the index of the block that was current when the first violation happened, or 0 if no block had yet been entered, and later violations do not change it.
- R8: With `mode_prevent` = 1, `stall` is high for the whole cycle after the edge that accepted a transfer target, and a retire offered in that cycle is not accepted.
- R9: With `mode_prevent` = 0, `stall` is high in that cycle only while the offered retire has `ret_ctrl` = 1. A retire with `ret_ctrl` = 0 is accepted.
- R10: A retire that is neither a block start nor a transfer target has no effect. `invalid` does not change and the current block stays the same.
- R11: After reset, `invalid`, `stall` and `fault_row` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_prevent | input | 1 | 1 = prevention mode, 0 = detection mode |
| func_base | input | ADDR_W | Base address of the active function |
| tbl_we | input | 1 | Table row write strobe |
| tbl_row | input | IDX_W | Block index of the row being written |
| tbl_off | input | OFF_W | Start offset of the block from the function base |
| tbl_s0 | input | IDX_W | First permitted successor block |
| tbl_s1 | input | IDX_W | Second permitted successor block |
| ret_valid | input | 1 | A retired instruction is offered |
| ret_pc | input | ADDR_W | PC of the offered instruction |
| ret_ctrl | input | 1 | The offered instruction is a branch or jump |
| stall | output | 1 | Offered retire is not accepted this cycle |
| invalid | output | 1 | Sticky control-flow violation flag |
| fault_row | output | IDX_W | Block being left at the first violation |

## Verification
A retire is accepted on a rising edge. Its verdict on `invalid` and `fault_row` is due one edge later, so the bench drives on falling edges, keeps the retire valid for exactly one edge, and samples both outputs at the second falling edge after it drove the retire. `stall` is a function of the check in flight and of the offered retire during the cycle after a target is accepted, so the bench samples it shortly after a falling edge in that cycle. It does this with both values of `ret_ctrl` in detection mode, and in prevention mode it also confirms that a retire held back in that cycle is accepted in the next one. Random walks over random tables mix legal and illegal transfers, and a bench model that works at the level of retires predicts every expected flag and index.

// File: rtl/bbc_pkg.sv
// Package: shared types for the basic-block successor checker.
// Assumes: nothing beyond IEEE 1800-2017.
package bbc_pkg;
    typedef enum logic {
        CHK_DETECT  = 1'b0,
        CHK_PREVENT = 1'b1
    } chk_mode_e;
endpackage

// File: rtl/bbc_table.sv
// Module: block table. It holds one row per basic block (start offset and two
// successors) and does a parallel match of a lookup offset against every
// loaded row. It also reads the successors of the current block.
// Assumes: rows are written before checking starts; reset empties all rows.
module bbc_table #(
    parameter int DEPTH = 8,
    parameter int OFF_W = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [IDX_W-1:0] wr_s0,
    input  logic [IDX_W-1:0] wr_s1,
    input  logic             lk_en,
    input  logic [OFF_W-1:0] lk_off,
    input  logic [IDX_W-1:0] cur_row,
    output logic             hit,
    output logic [IDX_W-1:0] hit_row,
    output logic [IDX_W-1:0] cur_s0,
    output logic [IDX_W-1:0] cur_s1
);
    logic [OFF_W-1:0] off_q [DEPTH];
    logic [IDX_W-1:0] s0_q  [DEPTH];
    logic [IDX_W-1:0] s1_q  [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;

    // Row storage: write the addressed row, and clear the valid bits on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_row == IDX_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    off_q[i] <= wr_off;
                    s0_q[i]  <= wr_s0;
                    s1_q[i]  <= wr_s1;
                end
            end
        end
    end

    // One offset comparator per row.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && lk_en && (off_q[g] == lk_off);
    end

    // Priority pick of the lowest matching row.
    always_comb begin
        hit     = 1'b0;
        hit_row = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_row = IDX_W'(i);
            end
        end
    end

    // Successor readout for the current block.
    assign cur_s0 = s0_q[cur_row];
    assign cur_s1 = s1_q[cur_row];
endmodule

// File: rtl/bbc_track.sv
// Module: transfer tracker. It registers each accepted retire as a function
// offset (stage A), resolves the stage-A entry against the table one cycle
// later, keeps the current block, and latches the first violation.
// Assumes: func_base is stable while a function runs; ADDR_W > OFF_W.
module bbc_track #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic              ret_ctrl,
    input  logic [ADDR_W-1:0] func_base,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_row,
    input  logic [IDX_W-1:0]  cur_s0,
    input  logic [IDX_W-1:0]  cur_s1,
    output logic              lk_en,
    output logic [OFF_W-1:0]  lk_off,
    output logic [IDX_W-1:0]  cur_row,
    output logic              busy_tgt,
    output logic              eval_vld,
    output logic              invalid,
    output logic [IDX_W-1:0]  fault_row
);
    logic [ADDR_W-1:0] diff;
    logic              in_range;
    logic              prev_ctrl_q;
    logic              a_vld_q, a_tgt_q, a_inr_q;
    logic [OFF_W-1:0]  a_off_q;
    logic              have_cur_q;
    logic [IDX_W-1:0]  cur_q;
    logic              inv_q;
    logic [IDX_W-1:0]  fault_q;
    logic              bad;

    // Offset of the offered PC inside the active function.
    assign diff     = ret_pc - func_base;
    assign in_range = (diff[ADDR_W-1:OFF_W] == '0);

    // Stage A: capture each accepted retire and whether it follows a branch or jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld_q     <= 1'b0;
            a_tgt_q     <= 1'b0;
            a_inr_q     <= 1'b0;
            a_off_q     <= '0;
            prev_ctrl_q <= 1'b0;
        end else begin
            a_vld_q <= accept;
            if (accept) begin
                a_tgt_q     <= prev_ctrl_q;
                a_inr_q     <= in_range;
                a_off_q     <= diff[OFF_W-1:0];
                prev_ctrl_q <= ret_ctrl;
            end
        end
    end

    assign lk_en  = a_vld_q && a_inr_q;
    assign lk_off = a_off_q;

    // Verdict: an illegal successor, or a transfer target that is not a block start.
    assign bad = a_vld_q && (hit ? (have_cur_q && (hit_row != cur_s0) && (hit_row != cur_s1))
                                 : a_tgt_q);

    // Current-block tracking and the sticky capture of the first violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_cur_q <= 1'b0;
            cur_q      <= '0;
            inv_q      <= 1'b0;
            fault_q    <= '0;
        end else begin
            if (bad && !inv_q) begin
                inv_q   <= 1'b1;
                fault_q <= cur_q;
            end
            if (a_vld_q && hit) begin
                cur_q      <= hit_row;
                have_cur_q <= 1'b1;
            end
        end
    end

    assign cur_row   = cur_q;
    assign busy_tgt  = a_vld_q && a_tgt_q;
    assign eval_vld  = a_vld_q;
    assign invalid   = inv_q;
    assign fault_row = fault_q;
endmodule

// File: rtl/bb_flow_checker.sv
// Module: top of the basic-block successor checker. It ties the table to the
// tracker and produces the retire back-pressure for the selected mode.
// Assumes: the processor retires an offered instruction only when stall is low.
module bb_flow_checker #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int DEPTH  = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   mode_prevent,
    input  logic [ADDR_W-1:0]                      func_base,
    input  logic                                   tbl_we,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] tbl_row,
    input  logic [OFF_W-1:0]                       tbl_off,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] tbl_s0,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] tbl_s1,
    input  logic                                   ret_valid,
    input  logic [ADDR_W-1:0]                      ret_pc,
    input  logic                                   ret_ctrl,
    output logic                                   stall,
    output logic                                   invalid,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] fault_row
);
    import bbc_pkg::*;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    chk_mode_e        mode;
    logic             accept;
    logic             lk_en, hit, busy_tgt, eval_vld;
    logic [OFF_W-1:0] lk_off;
    logic [IDX_W-1:0] hit_row, cur_row, cur_s0, cur_s1;

    assign mode = chk_mode_e'(mode_prevent);

    // Back-pressure: prevention holds every retire and detection holds only
    // branches and jumps while a transfer target is under check.
    assign stall  = busy_tgt && ((mode == CHK_PREVENT) || (ret_valid && ret_ctrl));
    assign accept = ret_valid && !stall;

    bbc_table #(.DEPTH(DEPTH), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_row(tbl_row), .wr_off(tbl_off), .wr_s0(tbl_s0), .wr_s1(tbl_s1),
        .lk_en(lk_en), .lk_off(lk_off), .cur_row(cur_row),
        .hit(hit), .hit_row(hit_row), .cur_s0(cur_s0), .cur_s1(cur_s1)
    );

    bbc_track #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .ret_pc(ret_pc), .ret_ctrl(ret_ctrl), .func_base(func_base),
        .hit(hit), .hit_row(hit_row), .cur_s0(cur_s0), .cur_s1(cur_s1),
        .lk_en(lk_en), .lk_off(lk_off), .cur_row(cur_row),
        .busy_tgt(busy_tgt), .eval_vld(eval_vld),
        .invalid(invalid), .fault_row(fault_row)
    );
endmodule

// File: rtl/bbc_checker.sv
// Module: property checker for bb_flow_checker, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module bbc_checker #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_prevent,
    input logic             ret_valid,
    input logic             ret_ctrl,
    input logic             stall,
    input logic             invalid,
    input logic [IDX_W-1:0] fault_row,
    input logic             busy_tgt,
    input logic             eval_vld
);
    // R7
    sticky_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |=> invalid);

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |=> $stable(fault_row));

    // R3
    rise_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(invalid) |-> $past(eval_vld));

    // R8
    prevent_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_prevent && busy_tgt) |-> stall);

    // R9
    detect_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_prevent && stall) |-> (ret_valid && ret_ctrl));

    // R8
    no_idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_tgt |-> !stall);
endmodule

bind bb_flow_checker bbc_checker #(.IDX_W(IDX_W)) u_bbc_chk (
    .clk(clk), .rst_n(rst_n), .mode_prevent(mode_prevent),
    .ret_valid(ret_valid), .ret_ctrl(ret_ctrl), .stall(stall),
    .invalid(invalid), .fault_row(fault_row),
    .busy_tgt(busy_tgt), .eval_vld(eval_vld)
);

// File: tb/tb_bb_flow_checker.sv
// Bench: directed corner cases plus seeded random walks, checked against a
// model that works at the level of retires.
module tb_bb_flow_checker;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 8;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = 3;
    localparam logic [ADDR_W-1:0] BASE = 16'h1200;

    logic              clk, rst_n, mode_prevent, tbl_we, ret_valid, ret_ctrl;
    logic [ADDR_W-1:0] func_base, ret_pc;
    logic [IDX_W-1:0]  tbl_row, tbl_s0, tbl_s1, fault_row;
    logic [OFF_W-1:0]  tbl_off;
    logic              stall, invalid;

    bb_flow_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .mode_prevent(mode_prevent), .func_base(func_base),
        .tbl_we(tbl_we), .tbl_row(tbl_row), .tbl_off(tbl_off), .tbl_s0(tbl_s0), .tbl_s1(tbl_s1),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_ctrl(ret_ctrl),
        .stall(stall), .invalid(invalid), .fault_row(fault_row)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // Bench copy of the table and model state.
    int toff [DEPTH];
    int ts0  [DEPTH];
    int ts1  [DEPTH];
    bit m_have, m_prev, m_inv;
    int m_cur, m_fidx;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_have = 0; m_prev = 0; m_inv = 0; m_cur = 0; m_fidx = 0;
    endfunction

    // Model of one accepted retire.
    function automatic void m_step(logic [ADDR_W-1:0] pc, bit ctrl);
        logic [ADDR_W-1:0] d;
        int k;
        d = pc - BASE;
        k = -1;
        if (d < (1 << OFF_W))
            for (int i = DEPTH - 1; i >= 0; i--)
                if (toff[i] == int'(d)) k = i;
        if (k >= 0) begin
            if (m_have && k != ts0[m_cur] && k != ts1[m_cur] && !m_inv) begin
                m_inv = 1; m_fidx = m_cur;
            end
            m_cur = k; m_have = 1;
        end else if (m_prev && !m_inv) begin
            m_inv = 1; m_fidx = m_cur;
        end
        m_prev = ctrl;
    endfunction

    task automatic do_reset(bit prevent);
        @(negedge clk);
        rst_n = 0; ret_valid = 0; ret_ctrl = 0; tbl_we = 0; mode_prevent = prevent;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_reset();
    endtask

    task automatic load_row(int i, int off, int s0, int s1);
        @(negedge clk);
        tbl_we = 1; tbl_row = IDX_W'(i); tbl_off = OFF_W'(off);
        tbl_s0 = IDX_W'(s0); tbl_s1 = IDX_W'(s1);
        toff[i] = off; ts0[i] = s0; ts1[i] = s1;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic load_fixed();
        for (int i = 0; i < DEPTH; i++) load_row(i, i * 12, (i + 1) % DEPTH, (i + 3) % DEPTH);
    endtask

    // One isolated retire, then check the verdict two falling edges later.
    task automatic retire(int off, bit ctrl, string req);
        @(negedge clk);
        ret_valid = 1; ret_pc = BASE + ADDR_W'(off); ret_ctrl = ctrl;
        m_step(ret_pc, ctrl);
        @(negedge clk);
        ret_valid = 0; ret_ctrl = 0;
        @(negedge clk);
        chk({req, " invalid"}, int'(invalid), int'(m_inv));
        chk({req, " fault_row"}, int'(fault_row), m_fidx);
    endtask

    // Back-pressure scenario: a jump, then its target, then a held retire.
    task automatic stall_case(bit prevent);
        do_reset(prevent);
        load_fixed();
        retire(0, 0, "R6");
        @(negedge clk);
        ret_valid = 1; ret_pc = BASE + 16'd2; ret_ctrl = 1; m_step(ret_pc, 1);
        @(negedge clk);
        ret_pc = BASE + 16'd12; ret_ctrl = 0; m_step(ret_pc, 0);
        @(negedge clk);
        ret_pc = BASE + 16'd13;
        if (prevent) begin
            ret_ctrl = 0; #1;
            chk("R8 stall after target", int'(stall), 1);
            @(negedge clk); #1;
            chk("R8 stall released", int'(stall), 0);
            m_step(ret_pc, 0);
        end else begin
            ret_ctrl = 1; #1;
            chk("R9 stall on jump", int'(stall), 1);
            ret_ctrl = 0; #1;
            chk("R9 no stall on plain", int'(stall), 0);
            m_step(ret_pc, 0);
        end
        @(negedge clk);
        ret_valid = 0; ret_ctrl = 0;
        @(negedge clk); #1;
        chk("R8/R9 stall idle", int'(stall), 0);
        // Block 1 is current; its successors are 2 and 4. Fall into 2 is legal.
        retire(24, 0, "R4 after stall");
        chk("R8/R9 invalid", int'(invalid), 0);
    endtask

    initial begin
        int cur, tgt, r;
        void'($urandom(32'd1234));
        func_base = BASE; rst_n = 0; mode_prevent = 0; tbl_we = 0;
        tbl_row = '0; tbl_off = '0; tbl_s0 = '0; tbl_s1 = '0;
        ret_valid = 0; ret_pc = '0; ret_ctrl = 0;
        m_reset();

        do_reset(0);
        #1;
        chk("R11 invalid", int'(invalid), 0);
        chk("R11 stall", int'(stall), 0);
        chk("R11 fault_row", int'(fault_row), 0);

        // Fixed table: row i at offset 12*i, s0 = i+1, s1 = i+3 (mod 8).
        load_fixed();
        retire(36, 0, "R6 first entry");
        retire(37, 1, "R10 inside");
        retire(48, 0, "R2 s0 entry");
        retire(49, 1, "R10 inside");
        retire(84, 0, "R3 s1 entry");
        retire(86, 1, "R10 inside");
        retire(24, 0, "R3 wrap s1");
        retire(25, 0, "R10 inside");
        retire(36, 0, "R4 legal fall");
        retire(37, 1, "R10 inside");
        retire(60, 0, "R3 illegal");
        retire(61, 1, "R7 sticky");
        retire(72, 0, "R7 sticky");

        // Overwritten row makes a fall-through illegal.
        do_reset(0);
        load_fixed();
        load_row(1, 12, 5, 4);
        retire(0, 0, "R6");
        retire(1, 1, "R10");
        retire(12, 0, "R1 s0 entry");
        retire(13, 0, "R10");
        retire(24, 0, "R4 illegal fall");

        // Target that is not a block start.
        do_reset(1);
        load_fixed();
        retire(0, 0, "R6");
        retire(5, 1, "R10");
        retire(7, 0, "R5 mid-block target");

        // Target outside the offset range.
        do_reset(0);
        load_fixed();
        retire(0, 0, "R6");
        retire(5, 1, "R10");
        retire(300, 0, "R5 out of range");

        // Target before any block: fault_row reports 0.
        do_reset(0);
        load_fixed();
        retire(5, 1, "R10 before entry");
        retire(6, 0, "R5 no block yet");

        stall_case(1);
        stall_case(0);

        // Random walks over random tables.
        for (int ep = 0; ep < 30; ep++) begin
            do_reset(bit'($urandom % 2));
            for (int i = 0; i < DEPTH; i++)
                load_row(i, i * 12 + int'($urandom % 4), int'($urandom % DEPTH), int'($urandom % DEPTH));
            cur = int'($urandom % DEPTH);
            retire(toff[cur], 0, "R6 random start");
            for (int st = 0; st < 15; st++) begin
                retire(toff[cur] + 1, 0, "R10 random");
                r = int'($urandom % 10);
                retire(toff[cur] + 2, 1, "R10 random");
                if (r == 0) begin
                    retire(toff[int'($urandom % DEPTH)] + 1, 0, "R5 random");
                end else begin
                    if (r == 1) tgt = int'($urandom % DEPTH);
                    else tgt = ($urandom % 2 == 0) ? ts0[cur] : ts1[cur];
                    retire(toff[tgt], 0, "R3 random");
                    cur = tgt;
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule